// File: doc/BRIEF.md
# Pixel Word Unpacker and Formatter

This block sits between a memory-fed word FIFO and a parallel panel data bus. It takes 32-bit words through a valid/ready handshake and sends one pixel per clock on a 24-bit output, with a valid strobe. Four static settings shape the stream. A word-length select picks between two RGB565 pixels per word and one 8:8:8 pixel per word. A byte-valid mask decides which pixel slots of a word are real. A bus-width select chooses how each pixel is laid onto the output lines. A narrowing flag cuts 8-bit components down to 6 bits for 18-bit panels.

Each accepted word is held until all of its valid pixels have been sent. Only after that does the input become ready again. The word-length, bus-width and narrowing settings are captured together with the word, so a settings change takes effect only on the next word.

Top module: `pixfmt_unpacker`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, pixValid is 0, pixData is 0 and inReady is 1.
- R2: inReady is 0 from the edge that accepts a word until the last of its pixels has been sent. A word is taken only on an edge where both inValid and inReady are 1.
- R3: With wordLen = 0 (16-bit pixels) and packMask = 0xF, a word gives two pixels on consecutive clocks, bits 15:0 first and bits 31:16 second. The first pixel is valid in the second cycle after the accepting edge.
- R4: In 16-bit mode, the lower halfword is sent only if packMask bits 1:0 are both set, and the upper halfword only if bits 3:2 are both set. A word with neither pair set gives no pixel.
- R5: With busWidth = 0 (16-bit bus), a 16-bit pixel is sent as {8'h00, halfword}.
- R6: With busWidth = 2 (18-bit bus), an RGB565 pixel (red 15:11, green 10:5, blue 4:0) is sent as {6'b0, R5, R5[4], G6, B5, B5[4]}.
- R7: With busWidth = 3 (24-bit bus), an RGB565 pixel is sent as {R5, R5[4:2], G6, G6[5:4], B5, B5[4:2]}.
- R8: With wordLen other than 0 (3 being the defined code), a word gives one pixel only when packMask[2:0] = 3'b111. Bits 31:24 of the word and packMask[3] are ignored. With narrowMap = 0 the pixel is word bits 23:0 (red 23:16, green 15:8, blue 7:0).
- R9: With narrowMap = 1 in 24-bit mode, the pixel is {6'b0, R[7:2], G[7:2], B[7:2]} on any bus width. In 16-bit mode, narrowMap has no effect.
- R10: With busWidth = 1 (8-bit bus), every word is accepted and dropped, and no pixel is produced.
- R11: pixData keeps its last value in every cycle where pixValid is 0.
- R12: wordLen, busWidth and narrowMap are sampled on the accepting edge. Changing them later does not alter the pixels of a word already taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | A word is offered on inWord |
| inReady | output | 1 | The block can take a word |
| inWord | input | 32 | Packed pixel word |
| wordLen | input | 2 | Pixel size: 0 = 16-bit, 3 = 24-bit |
| packMask | input | 4 | Byte-valid mask of the word |
| busWidth | input | 2 | Panel bus: 0 = 16, 1 = 8, 2 = 18, 3 = 24 bits |
| narrowMap | input | 1 | Reduce 8-bit components to 6 bits |
| pixValid | output | 1 | pixData carries a pixel this cycle |
| pixData | output | 24 | Formatted pixel |

## Verification
Several things are checked by assertions on every cycle. A stalled input is always followed by a pixel. pixData holds steady between pixels. Full-mask words produce the right number and spacing of valid strobes. Words on the 8-bit bus give no pixels. The top output lines stay clear on the 16-bit bus and under narrowing. Only the bench scenarios can show the bit-exact output: the component replication for 18-bit and 24-bit buses, which halfword comes first, which partial masks select which slot, that settings are captured at acceptance, and that a reset in the middle of a word clears it.

// File: rtl/pixfmt_pkg.sv
package pixfmt_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;
  localparam int MASK_W = WORD_W / 8;
  localparam int PIX_W  = 24;
  localparam int SLOTS  = WORD_W / HALF_W;

  typedef enum logic [1:0] {
    BUS_16 = 2'd0,
    BUS_8  = 2'd1,
    BUS_18 = 2'd2,
    BUS_24 = 2'd3
  } busSel_e;

  typedef struct packed {
    logic load;   // capture word and settings
    logic emit;   // send one pixel this edge
    logic upper;  // pixel comes from upper halfword
  } ctlStrobe_t;
endpackage

// File: rtl/pixfmt_ctrl.sv
module pixfmt_ctrl
  import pixfmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        wordLen,
  input  logic [MASK_W-1:0] packMask,
  input  logic [1:0]        busWidth,
  output logic              inReady,
  output ctlStrobe_t        ctl
);
  localparam logic [SLOTS-1:0] ONE = {{(SLOTS-1){1'b0}}, 1'b1};

  logic [SLOTS-1:0] pend;
  logic [SLOTS-1:0] slotsNew;

  // Which pixel slots of the offered word carry a pixel
  always_comb begin
    slotsNew = '0;
    if (busSel_e'(busWidth) != BUS_8) begin
      if (wordLen == 2'd0) begin
        for (int s = 0; s < SLOTS; s++) slotsNew[s] = &packMask[2*s +: 2];
      end else begin
        slotsNew[0] = &packMask[2:0];
      end
    end
  end

  assign inReady = (pend == '0);

  always_comb begin
    ctl.load  = inValid && inReady;
    ctl.emit  = (pend != '0);
    ctl.upper = ~pend[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         pend <= '0;
    else if (ctl.load) pend <= slotsNew;
    else               pend <= pend & (pend - ONE);  // retire lowest slot
  end
endmodule

// File: rtl/pixfmt_dpath.sv
module pixfmt_dpath
  import pixfmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [WORD_W-1:0] inWord,
  input  logic [1:0]        wordLen,
  input  logic [1:0]        busWidth,
  input  logic              narrowMap,
  output logic              pixValid,
  output logic [PIX_W-1:0]  pixData
);
  logic [WORD_W-1:0] wordQ;
  logic              is16Q;
  logic              mapQ;
  busSel_e           busQ;
  logic [HALF_W-1:0] half;
  logic [4:0]        r5, b5;
  logic [5:0]        g6;
  logic [7:0]        r8, g8, b8;
  logic [PIX_W-1:0]  fmt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ <= '0;
      is16Q <= 1'b1;
      mapQ  <= 1'b0;
      busQ  <= BUS_16;
    end else if (ctl.load) begin
      wordQ <= inWord;
      is16Q <= (wordLen == 2'd0);
      mapQ  <= narrowMap;
      busQ  <= busSel_e'(busWidth);
    end
  end

  always_comb begin
    half = ctl.upper ? wordQ[WORD_W-1 -: HALF_W] : wordQ[HALF_W-1:0];
    r5   = half[15:11];
    g6   = half[10:5];
    b5   = half[4:0];
    r8   = wordQ[23:16];
    g8   = wordQ[15:8];
    b8   = wordQ[7:0];
    if (is16Q) begin
      case (busQ)
        BUS_24:  fmt = {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]};
        BUS_18:  fmt = {6'b0, r5, r5[4], g6, b5, b5[4]};
        default: fmt = {8'b0, half};
      endcase
    end else if (mapQ) begin
      fmt = {6'b0, r8[7:2], g8[7:2], b8[7:2]};
    end else begin
      fmt = {r8, g8, b8};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixValid <= 1'b0;
      pixData  <= '0;
    end else begin
      pixValid <= ctl.emit;
      if (ctl.emit) pixData <= fmt;
    end
  end
endmodule

// File: rtl/pixfmt_unpacker.sv
module pixfmt_unpacker
  import pixfmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] inWord,
  input  logic [1:0]        wordLen,
  input  logic [MASK_W-1:0] packMask,
  input  logic [1:0]        busWidth,
  input  logic              narrowMap,
  output logic              pixValid,
  output logic [PIX_W-1:0]  pixData
);
  ctlStrobe_t ctl;

  pixfmt_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .wordLen  (wordLen),
    .packMask (packMask),
    .busWidth (busWidth),
    .inReady  (inReady),
    .ctl      (ctl)
  );

  pixfmt_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .inWord    (inWord),
    .wordLen   (wordLen),
    .busWidth  (busWidth),
    .narrowMap (narrowMap),
    .pixValid  (pixValid),
    .pixData   (pixData)
  );
endmodule

// File: rtl/pixfmt_unpacker_chk.sv
module pixfmt_unpacker_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inReady,
  input logic [1:0]  wordLen,
  input logic [3:0]  packMask,
  input logic [1:0]  busWidth,
  input logic        narrowMap,
  input logic        pixValid,
  input logic [23:0] pixData
);
  logic accept;
  assign accept = inValid && inReady;

  a_r1_reset_idle: assert property (@(posedge clk)
    !rstN |=> (!pixValid && inReady));

  a_r2_stall_sends: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |=> pixValid);

  a_r3_two_pixels: assert property (@(posedge clk) disable iff (!rstN)
    (accept && wordLen == 2'd0 && packMask == 4'hF && busWidth != 2'd1)
    |-> ##2 pixValid ##1 pixValid ##1 !pixValid);

  a_r5_narrow_bus_top: assert property (@(posedge clk) disable iff (!rstN)
    (accept && wordLen == 2'd0 && packMask == 4'hF && busWidth == 2'd0)
    |-> ##2 (pixData[23:16] == 8'h00) ##1 (pixData[23:16] == 8'h00));

  a_r8_one_pixel: assert property (@(posedge clk) disable iff (!rstN)
    (accept && wordLen != 2'd0 && packMask[2:0] == 3'b111 && busWidth != 2'd1)
    |-> ##2 pixValid ##1 !pixValid);

  a_r9_mapped_top: assert property (@(posedge clk) disable iff (!rstN)
    (accept && wordLen != 2'd0 && packMask[2:0] == 3'b111 && narrowMap && busWidth != 2'd1)
    |-> ##2 (pixValid && pixData[23:18] == 6'd0));

  a_r10_byte_bus_drop: assert property (@(posedge clk) disable iff (!rstN)
    (accept && busWidth == 2'd1) |=> !pixValid ##1 !pixValid);

  a_r11_hold_data: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |-> $stable(pixData));
endmodule

bind pixfmt_unpacker pixfmt_unpacker_chk u_chk (.*);

// File: tb/pixfmt_unpacker_bench.sv
`timescale 1ns/1ps
module pixfmt_unpacker_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inWord = '0;
  logic [1:0]  wordLen = '0;
  logic [3:0]  packMask = '0;
  logic [1:0]  busWidth = '0;
  logic        narrowMap = 1'b0;
  logic        inReady;
  logic        pixValid;
  logic [23:0] pixData;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;  // 250 MHz

  pixfmt_unpacker u_pixfmt_unpacker (.*);

  typedef struct packed {
    logic [31:0] word;
    logic [1:0]  len;
    logic [3:0]  mask;
    logic [1:0]  bus;
    logic        map;
    logic [1:0]  nPix;
    logic [23:0] exp0;
    logic [23:0] exp1;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{32'hF81F07E0, 2'd0, 4'hF, 2'd0, 1'b0, 2'd2, 24'h0007E0, 24'h00F81F},  // R3 R5
    '{32'hF81F07E0, 2'd0, 4'hF, 2'd3, 1'b0, 2'd2, 24'h00FF00, 24'hFF00FF},  // R7
    '{32'hF81F07E0, 2'd0, 4'hF, 2'd2, 1'b0, 2'd2, 24'h000FC0, 24'h03F03F},  // R6
    '{32'h84101234, 2'd0, 4'hC, 2'd3, 1'b0, 2'd1, 24'h848284, 24'h000000},  // R4 R7
    '{32'hFFFF8410, 2'd0, 4'h3, 2'd2, 1'b0, 2'd1, 24'h021821, 24'h000000},  // R4 R6
    '{32'h123407E0, 2'd0, 4'h7, 2'd0, 1'b0, 2'd1, 24'h0007E0, 24'h000000},  // R4
    '{32'h12345678, 2'd0, 4'h0, 2'd3, 1'b0, 2'd0, 24'h000000, 24'h000000},  // R4
    '{32'hAB123456, 2'd3, 4'h7, 2'd3, 1'b0, 2'd1, 24'h123456, 24'h000000},  // R8
    '{32'hCD123456, 2'd3, 4'hF, 2'd0, 1'b0, 2'd1, 24'h123456, 24'h000000},  // R8
    '{32'h00FF8040, 2'd3, 4'h7, 2'd2, 1'b1, 2'd1, 24'h03F810, 24'h000000},  // R9
    '{32'h00FFFFFF, 2'd3, 4'h7, 2'd3, 1'b1, 2'd1, 24'h03FFFF, 24'h000000},  // R9
    '{32'h00123456, 2'd3, 4'h3, 2'd3, 1'b0, 2'd0, 24'h000000, 24'h000000},  // R8
    '{32'h00123456, 2'd3, 4'h7, 2'd1, 1'b0, 2'd0, 24'h000000, 24'h000000},  // R10
    '{32'hF81F07E0, 2'd0, 4'hF, 2'd0, 1'b1, 2'd2, 24'h0007E0, 24'h00F81F}   // R9
  };

  function automatic string tagOf(input int i);
    case (i)
      0: return "R3";  1: return "R7";  2: return "R6";  3: return "R4";
      4: return "R4";  5: return "R4";  6: return "R4";  7: return "R8";
      8: return "R8";  9: return "R9"; 10: return "R9"; 11: return "R8";
      12: return "R10";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic runVec(input vec_t v, input string tag);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inWord = v.word; wordLen = v.len; packMask = v.mask;
    busWidth = v.bus; narrowMap = v.map; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    check(pixValid == (v.nPix != 0), {tag, " first slot valid"}, {23'b0, pixValid}, {23'b0, v.nPix != 0});
    if (v.nPix != 0) check(pixData == v.exp0, {tag, " first slot data"}, pixData, v.exp0);
    @(negedge clk);
    check(pixValid == (v.nPix == 2), {tag, " second slot valid"}, {23'b0, pixValid}, {23'b0, v.nPix == 2});
    if (v.nPix == 2) check(pixData == v.exp1, {tag, " second slot data"}, pixData, v.exp1);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!pixValid && pixData == 24'h0 && inReady, "R1 reset state", pixData, 24'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(!pixValid && inReady, "R1 after release", {22'b0, pixValid, inReady}, 24'h1);

    for (int i = 0; i < NV; i++) runVec(VEC[i], tagOf(i));

    // R2 and R11: second word offered while the first is still draining
    @(negedge clk);
    inWord = 32'h8410F81F; wordLen = 2'd0; packMask = 4'hF;
    busWidth = 2'd3; narrowMap = 1'b0; inValid = 1'b1;
    @(negedge clk);
    inWord = 32'h000007E0;
    check(!inReady, "R2 busy after accept", {23'b0, inReady}, 24'h0);
    @(negedge clk);
    check(!inReady, "R2 busy one pixel left", {23'b0, inReady}, 24'h0);
    check(pixValid && pixData == 24'hFF00FF, "R2 word A pixel 0", pixData, 24'hFF00FF);
    @(negedge clk);
    check(inReady, "R2 ready after last pixel", {23'b0, inReady}, 24'h1);
    check(pixValid && pixData == 24'h848284, "R2 word A pixel 1", pixData, 24'h848284);
    @(negedge clk);
    inValid = 1'b0;
    check(!inReady, "R2 word B taken", {23'b0, inReady}, 24'h0);
    check(!pixValid && pixData == 24'h848284, "R11 data held in gap", pixData, 24'h848284);
    @(negedge clk);
    check(pixValid && pixData == 24'h00FF00, "R2 word B pixel 0", pixData, 24'h00FF00);
    @(negedge clk);
    check(pixValid && pixData == 24'h000000, "R2 word B pixel 1", pixData, 24'h000000);

    // R12: settings changed after acceptance
    @(negedge clk);
    inWord = 32'h07E08410; wordLen = 2'd0; packMask = 4'hF;
    busWidth = 2'd3; narrowMap = 1'b0; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; busWidth = 2'd0; wordLen = 2'd3; narrowMap = 1'b1;
    @(negedge clk);
    check(pixValid && pixData == 24'h848284, "R12 pixel 0 keeps settings", pixData, 24'h848284);
    @(negedge clk);
    check(pixValid && pixData == 24'h00FF00, "R12 pixel 1 keeps settings", pixData, 24'h00FF00);

    // R1: reset in the middle of a word
    @(negedge clk);
    inWord = 32'hF81F07E0; wordLen = 2'd0; packMask = 4'hF;
    busWidth = 2'd0; narrowMap = 1'b0; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; rstN = 1'b0;
    @(negedge clk);
    check(!pixValid && inReady && pixData == 24'h0, "R1 reset mid-word", pixData, 24'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!pixValid && inReady, "R1 no leftover pixel", {22'b0, pixValid, inReady}, 24'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule